// File: doc/BRIEF.md
# Masked-Write GPIO Block with Shared Interrupt

This block drives and samples a bank of general-purpose pins through a small synchronous register bus. Each pin has a direction bit that switches its pad driver on or off. Each pin also has an output level. A single bus write can change any subset of output levels without a read-modify-write, because the upper half of the write word is a per-bit write mask for the data in the lower half. Pad inputs pass through a two-flop synchroniser. Software reads them back as a pin-state word.

The upper group of pins (8 to 15 by default) can raise one shared interrupt request. Each pin in that group is gated by its own enable bit, and the gated pins are ORed together. The request is meant for active-high sources.

A control register holds the block in reset or lets it run. It also gates the sampling logic for low power. At power-on the block sits in reset with its clock gated. Software writes 3 and then 1 to bring it up, and writes 2 to park it.

Top module: `mwgpio_top`

## Requirements
- R1: After the synchronous `rst` input, the control register reads 2 (held in reset, clock gated), `pad_oe`, `pad_out` and `irq_shared` are 0, and `bus_rdata` is 0.
- R2: The control register sits at address 0. Bit 0 is clock-enable and bit 1 is block-reset. It accepts writes in every state, and it reads back in bits 1:0 with the upper bits 0.
- R3: While the block-reset bit is 1, the direction, output and interrupt-enable registers are cleared at the next clock edge and stay 0. Bus writes to those registers are ignored.
- R4: The direction register sits at address 1. A 1 in bit n drives `pad_oe[n]` high from the clock edge that takes the write.
- R5: A write to address 2 updates output bit n to write-data bit n only where write-data bit 16+n is 1. Bits whose mask bit is 0 keep their value. `pad_out` shows the result from the edge that takes the write.
- R6: Address 3 returns the synchronised pin levels in bits 15:0. A `pad_in` value set before edge k appears on `bus_rdata` after edge k+2 and not after edge k+1.
- R7: The interrupt-enable register sits at address 4. Bits 7:0 enable pins 8 to 15 in order, and the register reads back in bits 7:0.
- R8: `irq_shared` is a registered OR, over pins 8 to 15, of each synchronised level ANDed with its enable bit. It follows `pad_in` with the same latency as R6.
- R9: While clock-enable is 0, the synchroniser holds its last values and `irq_shared` is 0 from the next edge on. Sampling resumes when the bit returns to 1.
- R10: Reads of addresses 5 to 7 return 0, and writes to them change no state.
- R11: `bus_rdata` is registered. It returns the register selected by `bus_addr` at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| irq_shared | output | 1 | Shared interrupt request for the upper pin group |

## Verification
The bench builds the block with its default parameters: 16 pins, a 32-bit data word, the shared group starting at pin 8, and two synchroniser stages. With these values every one of the 16 mask bits is reachable, including the all-zero mask. The eight-pin interrupt group can be probed with a lone enabled source, a lone disabled source, and the group's lowest and highest pins. The two-stage synchroniser makes the latency boundary in R6 observable from one cycle to the next: the value is still old after edge k+1 and new after edge k+2.

// File: rtl/mwgpio_pkg.sv
package mwgpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_DIR  = 3'd1,
    RA_OUT  = 3'd2,
    RA_PIN  = 3'd3,
    RA_IEN  = 3'd4
  } reg_addr_e;

  // control bit positions and power-on value (reset held, clock gated)
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam logic [1:0] CTRL_POR = 2'b10;
endpackage

// File: rtl/mwgpio_ctrl.sv
module mwgpio_ctrl
  import mwgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdata,
  output logic [1:0]        ctrl_q,
  output logic              clk_en,
  output logic              blk_rst
);
  logic ctrl_hit;
  assign ctrl_hit = wr_en && (addr == RA_CTRL);

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= CTRL_POR;
    else if (ctrl_hit) ctrl_q <= wdata;
  end

  assign clk_en  = ctrl_q[CTRL_EN_BIT];
  assign blk_rst = ctrl_q[CTRL_RST_BIT];

  // R1: power-on value is reset held, clock off
  a_r1_por_value: assert property (@(posedge clk) rst |=> ctrl_q == CTRL_POR);
  // R2: control register moves only on its own write
  a_r2_ctrl_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl_hit |=> $stable(ctrl_q));
endmodule

// File: rtl/mwgpio_regs.sv
module mwgpio_regs
  import mwgpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int IEN_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  blk_rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0]   dir_q,
  output logic [NUM_PINS-1:0]   out_q,
  output logic [IEN_W-1:0]      ien_q
);
  logic [NUM_PINS-1:0] wmask, wlevel;
  assign wmask  = wdata[2*NUM_PINS-1:NUM_PINS];
  assign wlevel = wdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst || blk_rst) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_DIR:  dir_q <= wlevel;
        RA_OUT:  out_q <= (out_q & ~wmask) | (wlevel & wmask);
        RA_IEN:  ien_q <= wlevel[IEN_W-1:0];
        default: ;
      endcase
    end
  end

  // R3: reset bit clears and holds the working registers
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
    blk_rst |=> (dir_q == '0 && out_q == '0 && ien_q == '0));
  // R5: bits outside the write mask keep their level
  a_r5_keep_unmasked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !blk_rst && addr == RA_OUT) |=>
      (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0));
  // R4: direction changes only through its own write
  a_r4_dir_quiet: assert property (@(posedge clk) disable iff (rst)
    (!blk_rst && !(wr_en && addr == RA_DIR)) |=> $stable(dir_q));
endmodule

// File: rtl/mwgpio_sync.sv
module mwgpio_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [NUM_PINS-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else if (en) begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign pin_o = stg_q[STAGES-1];

  // R9: gated clock freezes the sampled levels
  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pin_o));
endmodule

// File: rtl/mwgpio_irq.sv
module mwgpio_irq #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic [GRP_W-1:0] grp_lvl,
  input  logic [GRP_W-1:0] grp_en,
  output logic             irq_q
);
  logic [GRP_W-1:0] gated;
  assign gated = grp_lvl & grp_en;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= clk_en && (|gated);
  end

  // R9: no request while the clock is gated
  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !irq_q);
  // R8: with every enable clear no request appears
  a_r8_no_source: assert property (@(posedge clk) disable iff (rst)
    (grp_en == '0) |=> !irq_q);
endmodule

// File: rtl/mwgpio_top.sv
module mwgpio_top
  import mwgpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int IRQ_LO      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_shared
);
  localparam int GRP_W = NUM_PINS - IRQ_LO;

  logic [1:0]          ctrl_q;
  logic                clk_en, blk_rst;
  logic [NUM_PINS-1:0] dir_q, out_q, pin_s;
  logic [GRP_W-1:0]    ien_q;

  mwgpio_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[1:0]), .ctrl_q(ctrl_q), .clk_en(clk_en), .blk_rst(blk_rst)
  );

  mwgpio_regs #(.NUM_PINS(NUM_PINS), .IEN_W(GRP_W)) u_regs (
    .clk(clk), .rst(rst), .blk_rst(blk_rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[2*NUM_PINS-1:0]), .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q)
  );

  mwgpio_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en(clk_en), .pin_i(pad_in), .pin_o(pin_s)
  );

  mwgpio_irq #(.GRP_W(GRP_W)) u_irq (
    .clk(clk), .rst(rst), .clk_en(clk_en), .grp_lvl(pin_s[NUM_PINS-1:IRQ_LO]),
    .grp_en(ien_q), .irq_q(irq_shared)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        RA_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        RA_DIR:  bus_rdata <= DATA_W'(dir_q);
        RA_OUT:  bus_rdata <= DATA_W'(out_q);
        RA_PIN:  bus_rdata <= DATA_W'(pin_s);
        RA_IEN:  bus_rdata <= DATA_W'(ien_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  // R10: unused addresses read as zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > RA_IEN) |=> bus_rdata == '0);
endmodule

// File: tb/mwgpio_top_tb_top.sv
module mwgpio_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = 16'h0;
  logic [15:0] pad_out, pad_oe;
  logic        irq_shared;

  always #10 clk = ~clk;

  mwgpio_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_shared(irq_shared)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [1:0]  m_ctrl;
  logic [15:0] m_dir, m_out, m_s1, m_s2;
  logic [7:0]  m_ien;
  logic [31:0] m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] nrd;
    logic        nirq;
    if (rst) begin
      m_ctrl = 2'd2; m_dir = 0; m_out = 0; m_ien = 0;
      m_s1 = 0; m_s2 = 0; m_rd = 0; m_irq = 0;
    end else begin
      case (bus_addr)
        3'd0: nrd = {30'h0, m_ctrl};
        3'd1: nrd = {16'h0, m_dir};
        3'd2: nrd = {16'h0, m_out};
        3'd3: nrd = {16'h0, m_s2};
        3'd4: nrd = {24'h0, m_ien};
        default: nrd = 32'h0;
      endcase
      nirq = m_ctrl[0] && ((m_s2[15:8] & m_ien) != 8'h0);
      if (m_ctrl[0]) begin m_s2 = m_s1; m_s1 = pad_in; end
      if (m_ctrl[1]) begin
        m_dir = 0; m_out = 0; m_ien = 0;
      end else if (bus_wr) begin
        if (bus_addr == 3'd1) m_dir = bus_wdata[15:0];
        if (bus_addr == 3'd2) m_out = (m_out & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
        if (bus_addr == 3'd4) m_ien = bus_wdata[7:0];
      end
      if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata[1:0];
      m_rd = nrd; m_irq = nirq;
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(pad_out == m_out, "R5 pad_out", {16'h0, pad_out}, {16'h0, m_out});
      chk(pad_oe == m_dir, "R4 pad_oe", {16'h0, pad_oe}, {16'h0, m_dir});
      chk(irq_shared == m_irq, "R8 irq", {31'h0, irq_shared}, {31'h0, m_irq});
      chk(bus_rdata == m_rd, "R11 rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_rdata == 32'd2, "R1 ctrl", bus_rdata, 32'd2);
    chk(pad_oe == 16'h0 && pad_out == 16'h0, "R1 pads", {pad_oe, pad_out}, 32'h0);
    chk(irq_shared == 1'b0, "R1 irq", {31'h0, irq_shared}, 32'h0);
    cmp_on = 1'b1;

    wr(3'd0, 32'd3); wr(3'd0, 32'd1);
    rd(3'd0, v); chk(v == 32'd1, "R2 ctrl readback", v, 32'd1);

    wr(3'd1, 32'h0000_A5C3);
    chk(pad_oe == 16'hA5C3, "R4 dir", {16'h0, pad_oe}, 32'hA5C3);

    wr(3'd2, 32'hFFFF_1234); chk(pad_out == 16'h1234, "R5 full mask", {16'h0, pad_out}, 32'h1234);
    wr(3'd2, 32'h0001_0000); chk(pad_out == 16'h1234, "R5 bit0 clear", {16'h0, pad_out}, 32'h1234);
    wr(3'd2, 32'h00F0_00A0); chk(pad_out == 16'h12A4, "R5 nibble", {16'h0, pad_out}, 32'h12A4);
    wr(3'd2, 32'h8000_8000); chk(pad_out == 16'h92A4, "R5 top bit", {16'h0, pad_out}, 32'h92A4);
    wr(3'd2, 32'h0000_FFFF); chk(pad_out == 16'h92A4, "R5 empty mask", {16'h0, pad_out}, 32'h92A4);

    @(negedge clk); bus_addr = 3'd3; pad_in = 16'h5A3C;
    repeat (3) @(negedge clk);
    chk(bus_rdata == 32'h5A3C, "R6 pin state", bus_rdata, 32'h5A3C);
    pad_in = 16'hC3A5;
    repeat (2) @(negedge clk);
    chk(bus_rdata == 32'h5A3C, "R6 not yet", bus_rdata, 32'h5A3C);
    @(negedge clk);
    chk(bus_rdata == 32'hC3A5, "R6 arrived", bus_rdata, 32'hC3A5);

    wr(3'd4, 32'h0000_0081);
    rd(3'd4, v); chk(v == 32'h81, "R7 ien readback", v, 32'h81);

    pad_in = 16'h0100; repeat (3) @(negedge clk);
    chk(irq_shared == 1'b1, "R8 pin8", {31'h0, irq_shared}, 32'h1);
    pad_in = 16'h0200; repeat (3) @(negedge clk);
    chk(irq_shared == 1'b0, "R8 pin9 off", {31'h0, irq_shared}, 32'h0);
    pad_in = 16'h80FF; repeat (3) @(negedge clk);
    chk(irq_shared == 1'b1, "R8 pin15", {31'h0, irq_shared}, 32'h1);
    pad_in = 16'h00FF; repeat (3) @(negedge clk);
    chk(irq_shared == 1'b0, "R8 low pins", {31'h0, irq_shared}, 32'h0);

    pad_in = 16'h0100; repeat (3) @(negedge clk);
    wr(3'd0, 32'd0);
    @(negedge clk);
    chk(irq_shared == 1'b0, "R9 irq forced low", {31'h0, irq_shared}, 32'h0);
    bus_addr = 3'd3; pad_in = 16'hFFFF;
    repeat (4) @(negedge clk);
    chk(bus_rdata == 32'h0100, "R9 frozen", bus_rdata, 32'h0100);
    chk(irq_shared == 1'b0, "R9 irq stays low", {31'h0, irq_shared}, 32'h0);
    wr(3'd0, 32'd1);
    bus_addr = 3'd3; repeat (3) @(negedge clk);
    chk(bus_rdata == 32'hFFFF, "R9 resumed", bus_rdata, 32'hFFFF);

    wr(3'd0, 32'd3);
    @(negedge clk);
    chk(pad_oe == 16'h0 && pad_out == 16'h0, "R3 cleared", {pad_oe, pad_out}, 32'h0);
    wr(3'd1, 32'h0000_FFFF);
    chk(pad_oe == 16'h0, "R3 write ignored", {16'h0, pad_oe}, 32'h0);
    rd(3'd0, v); chk(v == 32'd3, "R2 reset state", v, 32'd3);
    wr(3'd0, 32'd1);
    rd(3'd4, v); chk(v == 32'h0, "R3 ien cleared", v, 32'h0);

    wr(3'd1, 32'h0000_00FF); wr(3'd2, 32'hFFFF_00F0);
    rd(3'd5, v); chk(v == 32'h0, "R10 addr5", v, 32'h0);
    rd(3'd7, v); chk(v == 32'h0, "R10 addr7", v, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    chk(pad_out == 16'h00F0 && pad_oe == 16'h00FF, "R10 write hole", {pad_oe, pad_out}, 32'h00FF_00F0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule